// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block produces the system reset for a processor core and the peripherals around it. It takes two digital verdicts from an external supply monitor. The first says the supply has climbed above the upper (rising) threshold. The second says the supply has sunk below the lower threshold, which sits a hysteresis margin under the upper one. It also takes an active-low reset pin from the board. All three inputs are brought into the clock domain through a two-stage synchronizer.

The sequencer runs a three-state machine: supply off, hold count, and run. Once the supply is good, reset stays asserted for a fixed release delay. Inside the hysteresis band a running system is left alone. A board reset pulse counts only after it has stayed low for a minimum number of cycles, and it restarts the release delay. While reset is active, the block drives the init strobes that empty the stacks, mask the interrupts and clear the status word. On release it pulses a fetch strobe next to a constant boot address.

Top module: `rst_sequencer`

## Requirements
- R1: While the block is not in the run state and the synchronized rising-threshold input is low, `core_rst` stays at 1.
- R2: After the rising-threshold input goes high (and the falling-threshold input is low), `core_rst` stays 1 for exactly 2^HOLD_LOG2 cycles of the hold state. Counted from the clock after the input changes, it is still 1 after edge 2^HOLD_LOG2+2 and falls to 0 after edge 2^HOLD_LOG2+3.
- R3: In the run state, a low rising-threshold input has no effect on `core_rst` while the falling-threshold input stays low.
- R4: A high falling-threshold input forces `core_rst` to 1 from any state. With the two-stage synchronizer, this happens after the third clock edge.
- R5: `ext_rst_n` held low for at least MIN_PULSE clock cycles sets `core_rst` to 1 after edge MIN_PULSE+3. The release delay restarts when the pin returns high, and reset falls after edge 2^HOLD_LOG2+3 counted from the pin's rise.
- R6: A low pulse on `ext_rst_n` shorter than MIN_PULSE cycles leaves `core_rst` at 0.
- R7: If the rising-threshold input falls during the hold count, the count is discarded. A new full release delay is measured from the next rise.
- R8: `periph_rst`, `stack_clr`, `irq_mask` and `stat_clr` always equal `core_rst`.
- R9: `boot_fetch` is 1 for exactly the one cycle in which `core_rst` first reads 0. `boot_addr` always reads BOOT_ADDR, which defaults to 0x0800.
- R10: The synchronous active-high `rst` input sets `core_rst` to 1 after the next edge. After `rst` drops, the release delay of R2 applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer itself |
| sup_above_rise | input | 1 | Supply is above the rising threshold |
| sup_below_fall | input | 1 | Supply is below the lower, hysteresis-adjusted threshold |
| ext_rst_n | input | 1 | Board reset pin, active low |
| core_rst | output | 1 | Core reset, active high |
| periph_rst | output | 1 | Peripheral reset, active high |
| stack_clr | output | 1 | Set all stack pointers to empty |
| irq_mask | output | 1 | Mask all interrupts |
| stat_clr | output | 1 | Clear the status register |
| boot_fetch | output | 1 | One-cycle strobe at release: start fetching |
| boot_addr | output | ADDR_W | First fetch address |

## Verification
The bench builds the block with HOLD_LOG2 = 5 and MIN_PULSE = 4. The full 2^16 delay would spend most of the cycle budget on a single power-up. With a 32-cycle hold, the bench can exercise power-up, hysteresis dwell, brown-out, a dip during the count, short and long board pulses and a self-reset in one run. MIN_PULSE = 4 makes the one-cycle boundary between a pulse of three cycles (ignored) and one of four (accepted) directly observable.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int unsigned         WIDTH   = 1,
  parameter int unsigned         STAGES  = 2,
  parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rs_pulse_qual.sv
module rs_pulse_qual #(
  parameter int unsigned MIN_PULSE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_n,
  output logic hit
);
  localparam int unsigned CW = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(MIN_PULSE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || lvl_n) begin
      cnt <= '0;
      hit <= 1'b0;
    end else begin
      if (!hit && cnt != CNT_TOP) cnt <= cnt + 1'b1;
      hit <= hit | (cnt == CNT_TOP);
    end
  end
endmodule

// File: rtl/rs_hold_ctr.sv
module rs_hold_ctr #(
  parameter int unsigned HOLD_LOG2 = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 en,
  output logic [HOLD_LOG2-1:0] cnt,
  output logic                 last
);
  localparam logic [HOLD_LOG2-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CNT_MAX);
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rstseq_pkg::*;
#(
  parameter int unsigned        HOLD_LOG2 = 16,
  parameter int unsigned        MIN_PULSE = 4,
  parameter int unsigned        SYNC_STG  = 2,
  parameter int unsigned        ADDR_W    = 14,
  parameter logic [ADDR_W-1:0]  BOOT_ADDR = 14'h0800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sup_above_rise,
  input  logic              sup_below_fall,
  input  logic              ext_rst_n,
  output logic              core_rst,
  output logic              periph_rst,
  output logic              stack_clr,
  output logic              irq_mask,
  output logic              stat_clr,
  output logic              boot_fetch,
  output logic [ADDR_W-1:0] boot_addr
);
  localparam int unsigned NIN = 3;
  localparam logic [NIN-1:0] SYNC_RST = 3'b110; // {ext_n=1, below=1, above=0}

  logic [NIN-1:0]       raw_in, sync_out;
  logic                 sup_hi_s, sup_lo_s, ext_s;
  logic                 ext_hit;
  logic                 cnt_clr, cnt_en, cnt_last;
  logic [HOLD_LOG2-1:0] hold_cnt;
  seq_state_e           state, nxt;

  assign raw_in = {ext_rst_n, sup_below_fall, sup_above_rise};

  rs_sync #(.WIDTH(NIN), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) i_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  assign sup_hi_s = sync_out[0];
  assign sup_lo_s = sync_out[1];
  assign ext_s    = sync_out[2];

  rs_pulse_qual #(.MIN_PULSE(MIN_PULSE)) i_qual (
    .clk(clk), .rst(rst), .lvl_n(ext_s), .hit(ext_hit)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF:  if (sup_hi_s && !sup_lo_s) nxt = ST_HOLD;
      ST_HOLD: begin
        if (sup_lo_s || !sup_hi_s)  nxt = ST_OFF;
        else if (ext_hit)           nxt = ST_HOLD;
        else if (cnt_last)          nxt = ST_RUN;
      end
      ST_RUN: begin
        if (sup_lo_s)     nxt = ST_OFF;
        else if (ext_hit) nxt = ST_HOLD;
      end
      default: nxt = ST_OFF;
    endcase
  end

  assign cnt_en  = (state == ST_HOLD);
  assign cnt_clr = (state != ST_HOLD) || (nxt != ST_HOLD) || ext_hit;

  rs_hold_ctr #(.HOLD_LOG2(HOLD_LOG2)) i_hold (
    .clk(clk), .rst(rst), .clr(cnt_clr), .en(cnt_en),
    .cnt(hold_cnt), .last(cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OFF;
      core_rst   <= 1'b1;
      periph_rst <= 1'b1;
      stack_clr  <= 1'b1;
      irq_mask   <= 1'b1;
      stat_clr   <= 1'b1;
      boot_fetch <= 1'b0;
    end else begin
      state      <= nxt;
      core_rst   <= (nxt != ST_RUN);
      periph_rst <= (nxt != ST_RUN);
      stack_clr  <= (nxt != ST_RUN);
      irq_mask   <= (nxt != ST_RUN);
      stat_clr   <= (nxt != ST_RUN);
      boot_fetch <= (state != ST_RUN) && (nxt == ST_RUN);
    end
  end

  assign boot_addr = BOOT_ADDR;
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk
  import rstseq_pkg::*;
#(
  parameter int unsigned        HOLD_LOG2 = 16,
  parameter int unsigned        ADDR_W    = 14,
  parameter logic [ADDR_W-1:0]  BOOT_ADDR = 14'h0800
) (
  input logic                 clk,
  input logic                 rst,
  input seq_state_e           state,
  input logic                 hi_s,
  input logic                 lo_s,
  input logic                 ext_s,
  input logic                 ext_hit,
  input logic [HOLD_LOG2-1:0] hold_cnt,
  input logic                 core_rst,
  input logic                 periph_rst,
  input logic                 stack_clr,
  input logic                 irq_mask,
  input logic                 stat_clr,
  input logic                 boot_fetch,
  input logic [ADDR_W-1:0]    boot_addr
);
  localparam logic [HOLD_LOG2-1:0] CNT_MAX = '1;

  a_r1_low_supply_holds: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN && !hi_s) |=> core_rst);

  a_r2_release_after_count: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> $past(hold_cnt) == CNT_MAX);

  a_r3_hysteresis_band: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !lo_s && !ext_hit) |=> !core_rst);

  a_r4_fall_trip: assert property (@(posedge clk) disable iff (rst)
    lo_s |=> core_rst);

  a_r5_ext_forces: assert property (@(posedge clk) disable iff (rst)
    ext_hit |=> core_rst);

  a_r6_qual_needs_low: assert property (@(posedge clk) disable iff (rst)
    ext_hit |-> !$past(ext_s));

  a_r8_init_follow: assert property (@(posedge clk) disable iff (rst)
    (periph_rst == core_rst) && (stack_clr == core_rst) &&
    (irq_mask == core_rst) && (stat_clr == core_rst));

  a_r9_boot_pulse: assert property (@(posedge clk) disable iff (rst)
    boot_fetch |-> $fell(core_rst));

  a_r9_boot_addr: assert property (@(posedge clk) disable iff (rst)
    boot_addr == BOOT_ADDR);

  a_r10_self_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> core_rst);
endmodule

bind rst_sequencer rst_sequencer_chk #(
  .HOLD_LOG2(HOLD_LOG2), .ADDR_W(ADDR_W), .BOOT_ADDR(BOOT_ADDR)
) i_chk (
  .clk(clk), .rst(rst), .state(state), .hi_s(sup_hi_s), .lo_s(sup_lo_s),
  .ext_s(ext_s), .ext_hit(ext_hit), .hold_cnt(hold_cnt),
  .core_rst(core_rst), .periph_rst(periph_rst), .stack_clr(stack_clr),
  .irq_mask(irq_mask), .stat_clr(stat_clr), .boot_fetch(boot_fetch),
  .boot_addr(boot_addr)
);

// File: tb/test_rst_sequencer.sv
module test_rst_sequencer;
  localparam int unsigned HL = 5;
  localparam int unsigned P  = 4;
  localparam int unsigned H  = 1 << HL;
  localparam int unsigned AW = 14;
  localparam logic [AW-1:0] BOOT = 14'h0800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hi = 1'b0, lo = 1'b1, ext_n = 1'b1;
  logic core_rst, periph_rst, stack_clr, irq_mask, stat_clr, boot_fetch;
  logic [AW-1:0] boot_addr;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  typedef struct {
    int   at;
    logic exp_rst;
    logic chk_boot;
    logic exp_boot;
    int   req;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  always #5 clk = ~clk;

  rst_sequencer #(.HOLD_LOG2(HL), .MIN_PULSE(P), .ADDR_W(AW), .BOOT_ADDR(BOOT)) i_rst_sequencer (
    .clk(clk), .rst(rst), .sup_above_rise(hi), .sup_below_fall(lo), .ext_rst_n(ext_n),
    .core_rst(core_rst), .periph_rst(periph_rst), .stack_clr(stack_clr),
    .irq_mask(irq_mask), .stat_clr(stat_clr), .boot_fetch(boot_fetch),
    .boot_addr(boot_addr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
      cur = exp_q.pop_front();
      total++;
      if (cur.at != cyc || core_rst !== cur.exp_rst) begin
        bad++;
        $display("FAIL R%0d cyc=%0d core_rst=%b expected %b", cur.req, cyc, core_rst, cur.exp_rst);
      end
      // R8: init strobes track core reset
      if ({periph_rst, stack_clr, irq_mask, stat_clr} !== {4{cur.exp_rst}}) begin
        bad++;
        $display("FAIL R8 cyc=%0d init=%b expected %b", cyc,
                 {periph_rst, stack_clr, irq_mask, stat_clr}, {4{cur.exp_rst}});
      end
      if (cur.chk_boot) begin
        // R9: fetch strobe and boot address
        if (boot_fetch !== cur.exp_boot || boot_addr !== BOOT) begin
          bad++;
          $display("FAIL R9 cyc=%0d boot_fetch=%b addr=%h expected %b addr=%h",
                   cyc, boot_fetch, boot_addr, cur.exp_boot, BOOT);
        end
      end
    end
  end

  task automatic mark(input int off, input logic r, input int req);
    exp_q.push_back('{at: cyc + off, exp_rst: r, chk_boot: 1'b0, exp_boot: 1'b0, req: req});
  endtask

  task automatic markb(input int off, input logic r, input logic b, input int req);
    exp_q.push_back('{at: cyc + off, exp_rst: r, chk_boot: 1'b1, exp_boot: b, req: req});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired at cyc=%0d", cyc);
    summary();
  end

  initial begin
    // R10: reset state while rst is high
    markb(1, 1'b1, 1'b0, 10);
    markb(2, 1'b1, 1'b0, 10);
    idle(3);
    rst = 1'b0;
    // R1: supply low keeps reset
    mark(5, 1'b1, 1);
    mark(10, 1'b1, 1);
    idle(12);

    // R2 + R9: power-up release timing
    hi = 1'b1; lo = 1'b0;
    mark(H + 2, 1'b1, 2);
    markb(H + 3, 1'b0, 1'b1, 9);
    markb(H + 4, 1'b0, 1'b0, 9);
    idle(H + 6);

    // R3: inside hysteresis band, no effect
    hi = 1'b0;
    mark(5, 1'b0, 3);
    mark(20, 1'b0, 3);
    idle(22);
    hi = 1'b1;
    idle(3);

    // R4: falling threshold trips reset after third edge
    hi = 1'b0; lo = 1'b1;
    mark(2, 1'b0, 4);
    mark(3, 1'b1, 4);
    idle(6);
    hi = 1'b1; lo = 1'b0;
    mark(H + 2, 1'b1, 2);
    markb(H + 3, 1'b0, 1'b1, 9);
    idle(H + 5);

    // R7: dip during hold restarts the count
    hi = 1'b0; lo = 1'b1;
    idle(5);
    hi = 1'b1; lo = 1'b0;
    mark(H + 3, 1'b1, 7);
    idle(10);
    hi = 1'b0;
    idle(5);
    hi = 1'b1;
    mark(H + 2, 1'b1, 7);
    mark(H + 3, 1'b0, 7);
    idle(H + 5);

    // R6: short board pulse ignored
    ext_n = 1'b0;
    mark(P + 3, 1'b0, 6);
    mark(P + 8, 1'b0, 6);
    idle(P - 1);
    ext_n = 1'b1;
    idle(12);

    // R5: pulse of exactly MIN_PULSE cycles
    ext_n = 1'b0;
    mark(P + 2, 1'b0, 5);
    mark(P + 3, 1'b1, 5);
    idle(P);
    ext_n = 1'b1;
    mark(H + 2, 1'b1, 5);
    markb(H + 3, 1'b0, 1'b1, 5);
    idle(H + 5);

    // R5: long board pulse, delay counted from pin release
    ext_n = 1'b0;
    mark(10, 1'b1, 5);
    idle(20);
    ext_n = 1'b1;
    mark(H + 2, 1'b1, 5);
    mark(H + 3, 1'b0, 5);
    idle(H + 5);

    // R10: self reset mid-run, then release again
    rst = 1'b1;
    mark(1, 1'b1, 10);
    idle(2);
    rst = 1'b0;
    mark(H + 2, 1'b1, 10);
    mark(H + 3, 1'b0, 10);
    idle(H + 5);

    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R1 pending expectations=%0d expected 0", exp_q.size());
    end
    summary();
  end
endmodule